// File: doc/BRIEF.md
# Ethernet Controller Status and Mode Register Bank

This block holds the byte-wide control state of a simple Ethernet controller. It keeps two status bytes, one for transmit and one for receive, with an interrupt mask for each. It also keeps three mode bytes, for transmit, receive and reset, and the six bytes of the station address. Software reaches every byte through a single-cycle write strobe and a combinational read port, both selected by a four-bit byte offset.

The transmitter and the receiver report their events on single-cycle pulse inputs. The bank turns those pulses into status values. It drives one interrupt line per direction: the line is high when any status bit is set together with the matching mask bit. It also drives a receive-accept flag from the receive mode, and it presents the station address as one 48-bit vector.

A status byte has no plain write-all-ones behaviour. Writing 0xFF to the transmit status returns it to its ready value, 0x80. Writing 0xFF to the receive status clears it to 0x00.

Top module: `eth_ctl_regs`

## Requirements
- R1: After reset, offset 0 (transmit status) reads 0x80 and every other offset reads 0x00. Both interrupt lines, the receive-accept flag and the station address output are low.
- R2: Offset 1 (transmit mask), 3 (receive mask), 4 (transmit mode), 5 (receive mode) and 6 (reset mode) each store a written byte unchanged, and the byte reads back at the same offset.
- R3: A write of 0xFF to offset 0 leaves the transmit status at 0x80. Any other value written there is stored as written.
- R4: A write of 0xFF to offset 2 leaves the receive status at 0x00. Any other value written there is stored as written.
- R5: A one-cycle pulse on `tx_done` sets the transmit status to 0x80. A one-cycle pulse on `rx_frame` sets the receive status to 0x80. Each takes effect at the next clock edge.
- R6: When an event pulse and a software write hit the same status byte in the same cycle, the event decides the result, which is 0x80.
- R7: `rx_accept` is high exactly when bit 0 or bit 1 of the receive mode byte (offset 5) is set. The other bits of that byte have no effect on it.
- R8: `tx_irq` is high when the bitwise AND of the transmit status and the transmit mask is nonzero. `rx_irq` is formed the same way from the receive status and the receive mask.
- R9: Offsets 8 to 13 hold the station address, one byte each, and each byte reads back at its offset. The byte at offset 8 is the first on the wire and appears on `station_addr[47:40]`; offset 13 appears on `station_addr[7:0]`.
- R10: Offsets 7, 14 and 15 read 0x00. Writes to them change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one cycle |
| reg_addr | input | 4 | Byte offset for both read and write |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Byte at `reg_addr`, combinational |
| tx_done | input | 1 | Pulse: a transmit has completed |
| rx_frame | input | 1 | Pulse: a frame has been received |
| rx_accept | output | 1 | The receiver may take incoming frames |
| tx_irq | output | 1 | Masked transmit interrupt |
| rx_irq | output | 1 | Masked receive interrupt |
| station_addr | output | 48 | Station address, first byte on the wire in the top bits |

## Verification
Some rules are checked on every cycle by the assertions. These are: an event forces 0x80 on the next edge even against a write; writing all-ones gives the clear value of each status byte; unmapped offsets read zero; a zero mask silences its interrupt; the station address holds steady unless one of its offsets is written; and a receive-mode write with both low bits clear drops `rx_accept`.

The bench scenarios cover what a per-cycle rule cannot show. They check that ordinary values are stored and read back, and they check the reset contents of the whole map. They check that byte order on the address vector follows the offsets. They also check that an interrupt follows the overlap of particular status and mask patterns, and that an ignored write leaves the neighbouring registers untouched.

// File: rtl/ethregs_pkg.sv
package ethregs_pkg;
    localparam int unsigned BYTE_W        = 8;
    localparam int unsigned STATION_BYTES = 6;

    // byte offsets of the register map
    localparam int unsigned OFF_TX_STAT   = 0;
    localparam int unsigned OFF_TX_MASK   = 1;
    localparam int unsigned OFF_RX_STAT   = 2;
    localparam int unsigned OFF_RX_MASK   = 3;
    localparam int unsigned OFF_TX_MODE   = 4;
    localparam int unsigned OFF_RX_MODE   = 5;
    localparam int unsigned OFF_RST_MODE  = 6;
    localparam int unsigned OFF_STATION   = 8;

    // status byte code values
    localparam logic [BYTE_W-1:0] STAT_READY    = 8'h80;
    localparam logic [BYTE_W-1:0] STAT_IDLE     = 8'h00;
    localparam logic [BYTE_W-1:0] STAT_CLR_CODE = 8'hFF;
endpackage

// File: rtl/ethregs_status.sv
module ethregs_status
    import ethregs_pkg::*;
#(
    parameter logic [BYTE_W-1:0] RESET_VAL = STAT_IDLE,
    parameter logic [BYTE_W-1:0] CLEAR_VAL = STAT_IDLE,
    parameter logic [BYTE_W-1:0] EVENT_VAL = STAT_READY
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              event_i,
    input  logic [BYTE_W-1:0] mask_i,
    output logic [BYTE_W-1:0] stat_q,
    output logic              irq_o
);
    logic [BYTE_W-1:0] stat_d;

    // hardware event outranks the software write
    always_comb begin
        stat_d = stat_q;
        if (event_i) begin
            stat_d = EVENT_VAL;
        end else if (wr_sel) begin
            stat_d = (wr_data == STAT_CLR_CODE) ? CLEAR_VAL : wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= RESET_VAL;
        end else begin
            stat_q <= stat_d;
        end
    end

    always_comb begin
        irq_o = |(stat_q & mask_i);
    end

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        event_i |=> (stat_q == EVENT_VAL)); // R6

    AST_CLEAR_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel && !event_i && wr_data == STAT_CLR_CODE) |=> (stat_q == CLEAR_VAL)); // R3

    AST_MASK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_i == '0) |-> !irq_o); // R8
endmodule

// File: rtl/ethregs_station.sv
module ethregs_station
    import ethregs_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned NBYTES = STATION_BYTES,
    parameter int unsigned BASE   = OFF_STATION
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic [BYTE_W-1:0]        wr_data,
    output logic [NBYTES*BYTE_W-1:0] station_o,
    output logic [BYTE_W-1:0]        rd_byte,
    output logic                     rd_hit
);
    localparam int unsigned VEC_W = NBYTES * BYTE_W;

    logic [NBYTES-1:0] sel;
    logic [BYTE_W-1:0] byte_q [NBYTES];

    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
        assign sel[i] = (reg_addr == ADDR_W'(BASE + i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                byte_q[i] <= '0;
            end else if (wr_en && sel[i]) begin
                byte_q[i] <= wr_data;
            end
        end

        // first byte on the wire sits in the top bits
        assign station_o[VEC_W-1-i*BYTE_W -: BYTE_W] = byte_q[i];
    end

    always_comb begin
        rd_byte = '0;
        for (int i = 0; i < NBYTES; i++) begin
            if (sel[i]) rd_byte = byte_q[i];
        end
        rd_hit = |sel;
    end

    AST_STATION_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && |sel) |=> $stable(station_o)); // R9
endmodule

// File: rtl/eth_ctl_regs.sv
module eth_ctl_regs
    import ethregs_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [ADDR_W-1:0]               reg_addr,
    input  logic [BYTE_W-1:0]               wr_data,
    output logic [BYTE_W-1:0]               rd_data,
    input  logic                            tx_done,
    input  logic                            rx_frame,
    output logic                            rx_accept,
    output logic                            tx_irq,
    output logic                            rx_irq,
    output logic [STATION_BYTES*BYTE_W-1:0] station_addr
);
    localparam int unsigned STATION_END = OFF_STATION + STATION_BYTES - 1;

    logic [BYTE_W-1:0] tx_stat, rx_stat;
    logic [BYTE_W-1:0] tx_mask, rx_mask, tx_mode, rx_mode, rst_mode;
    logic [BYTE_W-1:0] st_rd_byte;
    logic              st_rd_hit;
    logic              wr_tx_stat, wr_rx_stat;

    assign wr_tx_stat = wr_en && (reg_addr == ADDR_W'(OFF_TX_STAT));
    assign wr_rx_stat = wr_en && (reg_addr == ADDR_W'(OFF_RX_STAT));

    ethregs_status #(
        .RESET_VAL(STAT_READY), .CLEAR_VAL(STAT_READY), .EVENT_VAL(STAT_READY)
    ) i_tx_status (
        .clk(clk), .rst_n(rst_n), .wr_sel(wr_tx_stat), .wr_data(wr_data),
        .event_i(tx_done), .mask_i(tx_mask), .stat_q(tx_stat), .irq_o(tx_irq)
    );

    ethregs_status #(
        .RESET_VAL(STAT_IDLE), .CLEAR_VAL(STAT_IDLE), .EVENT_VAL(STAT_READY)
    ) i_rx_status (
        .clk(clk), .rst_n(rst_n), .wr_sel(wr_rx_stat), .wr_data(wr_data),
        .event_i(rx_frame), .mask_i(rx_mask), .stat_q(rx_stat), .irq_o(rx_irq)
    );

    ethregs_station #(
        .ADDR_W(ADDR_W), .NBYTES(STATION_BYTES), .BASE(OFF_STATION)
    ) i_station (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr),
        .wr_data(wr_data), .station_o(station_addr),
        .rd_byte(st_rd_byte), .rd_hit(st_rd_hit)
    );

    // plain mask and mode bytes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_mask  <= '0;
            rx_mask  <= '0;
            tx_mode  <= '0;
            rx_mode  <= '0;
            rst_mode <= '0;
        end else if (wr_en) begin
            if (reg_addr == ADDR_W'(OFF_TX_MASK))  tx_mask  <= wr_data;
            if (reg_addr == ADDR_W'(OFF_RX_MASK))  rx_mask  <= wr_data;
            if (reg_addr == ADDR_W'(OFF_TX_MODE))  tx_mode  <= wr_data;
            if (reg_addr == ADDR_W'(OFF_RX_MODE))  rx_mode  <= wr_data;
            if (reg_addr == ADDR_W'(OFF_RST_MODE)) rst_mode <= wr_data;
        end
    end

    assign rx_accept = |rx_mode[1:0];

    always_comb begin
        rd_data = '0;
        if (st_rd_hit) begin
            rd_data = st_rd_byte;
        end else begin
            case (reg_addr)
                ADDR_W'(OFF_TX_STAT):  rd_data = tx_stat;
                ADDR_W'(OFF_TX_MASK):  rd_data = tx_mask;
                ADDR_W'(OFF_RX_STAT):  rd_data = rx_stat;
                ADDR_W'(OFF_RX_MASK):  rd_data = rx_mask;
                ADDR_W'(OFF_TX_MODE):  rd_data = tx_mode;
                ADDR_W'(OFF_RX_MODE):  rd_data = rx_mode;
                ADDR_W'(OFF_RST_MODE): rd_data = rst_mode;
                default:               rd_data = '0;
            endcase
        end
    end

    AST_RX_ACCEPT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_addr == ADDR_W'(OFF_RX_MODE) && wr_data[1:0] == 2'b00)
        |=> !rx_accept); // R7

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(OFF_RST_MODE + 1) || int'(reg_addr) > STATION_END)
        |-> (rd_data == '0)); // R10
endmodule

// File: tb/test_eth_ctl_regs.sv
module test_eth_ctl_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic        tx_done = 1'b0;
    logic        rx_frame = 1'b0;
    logic        rx_accept, tx_irq, rx_irq;
    logic [47:0] station_addr;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    eth_ctl_regs i_eth_ctl_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr),
        .wr_data(wr_data), .rd_data(rd_data), .tx_done(tx_done),
        .rx_frame(rx_frame), .rx_accept(rx_accept), .tx_irq(tx_irq),
        .rx_irq(rx_irq), .station_addr(station_addr)
    );

    typedef struct packed {
        logic [3:0] req;
        logic [3:0] off;
        logic [7:0] wd;
        logic [7:0] exp;
    } vec_t;

    localparam vec_t VEC [0:12] = '{
        '{4'd2,  4'd1,  8'h5A, 8'h5A},  // R2 transmit mask
        '{4'd2,  4'd3,  8'hC3, 8'hC3},  // R2 receive mask
        '{4'd2,  4'd4,  8'h11, 8'h11},  // R2 transmit mode
        '{4'd2,  4'd6,  8'h7E, 8'h7E},  // R2 reset mode
        '{4'd2,  4'd5,  8'h04, 8'h04},  // R2 receive mode
        '{4'd3,  4'd0,  8'hFF, 8'h80},  // R3 clear code
        '{4'd3,  4'd0,  8'h12, 8'h12},  // R3 plain value
        '{4'd4,  4'd2,  8'hFF, 8'h00},  // R4 clear code
        '{4'd4,  4'd2,  8'h34, 8'h34},  // R4 plain value
        '{4'd9,  4'd8,  8'h02, 8'h02},  // R9 first address byte
        '{4'd9,  4'd13, 8'hAB, 8'hAB},  // R9 last address byte
        '{4'd10, 4'd7,  8'h99, 8'h00},  // R10 hole in map
        '{4'd10, 4'd15, 8'h55, 8'h00}   // R10 top of map
    };

    task automatic check(input string req, input logic [47:0] act,
                         input logic [47:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; reg_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [3:0] a,
                            input logic [7:0] exp);
        reg_addr = a;
        #1;
        check(req, {40'd0, rd_data}, {40'd0, exp}, $sformatf("read offset %0d", a));
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #5 rst_n = 1'b1;
        @(negedge clk);

        // R1 reset contents
        for (int a = 0; a < 16; a++) begin
            rd_check("R1", 4'(a), (a == 0) ? 8'h80 : 8'h00);
        end
        check("R1", {45'd0, tx_irq, rx_irq, rx_accept}, 48'd0, "irq/accept");
        check("R1", station_addr, 48'd0, "station");

        // table walk
        for (int i = 0; i <= 12; i++) begin
            wr(VEC[i].off, VEC[i].wd);
            rd_check($sformatf("R%0d", VEC[i].req), VEC[i].off, VEC[i].exp);
        end
        check("R10", {40'd0, rd_data}, 48'd0, "unmapped read");
        rd_check("R10", 4'd1, 8'h5A);
        rd_check("R10", 4'd6, 8'h7E);

        // R7 receive accept gating
        check("R7", {47'd0, rx_accept}, 48'd0, "mode 04");
        wr(4'd5, 8'h01); check("R7", {47'd0, rx_accept}, 48'd1, "mode 01");
        wr(4'd5, 8'h02); check("R7", {47'd0, rx_accept}, 48'd1, "mode 02");
        wr(4'd5, 8'hFC); check("R7", {47'd0, rx_accept}, 48'd0, "mode FC");

        // R8 interrupt formation
        wr(4'd1, 8'h01); wr(4'd0, 8'h80);
        check("R8", {47'd0, tx_irq}, 48'd0, "tx 80&01");
        wr(4'd0, 8'h81);
        check("R8", {47'd0, tx_irq}, 48'd1, "tx 81&01");
        wr(4'd3, 8'h80); wr(4'd2, 8'hFF);
        check("R8", {47'd0, rx_irq}, 48'd0, "rx 00&80");

        // R5 events
        @(negedge clk); rx_frame = 1'b1;
        @(negedge clk); rx_frame = 1'b0;
        rd_check("R5", 4'd2, 8'h80);
        check("R8", {47'd0, rx_irq}, 48'd1, "rx 80&80");
        wr(4'd0, 8'h05);
        @(negedge clk); tx_done = 1'b1;
        @(negedge clk); tx_done = 1'b0;
        rd_check("R5", 4'd0, 8'h80);

        // R6 event beats a write in the same cycle
        @(negedge clk);
        wr_en = 1'b1; reg_addr = 4'd2; wr_data = 8'h05; rx_frame = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rx_frame = 1'b0;
        rd_check("R6", 4'd2, 8'h80);
        @(negedge clk);
        wr_en = 1'b1; reg_addr = 4'd0; wr_data = 8'h33; tx_done = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tx_done = 1'b0;
        rd_check("R6", 4'd0, 8'h80);

        // R9 station address byte order
        for (int b = 0; b < 6; b++) wr(4'(8 + b), 8'(8'h10 + b));
        check("R9", station_addr, 48'h101112131415, "station vector");
        rd_check("R9", 4'd10, 8'h12);

        // R10 unmapped writes leave everything unchanged
        wr(4'd14, 8'hEE);
        check("R10", station_addr, 48'h101112131415, "station after hole write");
        rd_check("R10", 4'd14, 8'h00);
        rd_check("R10", 4'd3, 8'h80);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule